// File: doc/BRIEF.md
# Reference Clock Failover Sequencer

This block is a synchronous control state machine. It steers a clock generator from one reference input to the other when the reference in use is flagged as failed. On a failure it first freezes the loop by dropping the phase-detector enable, so the oscillator keeps its last frequency. It then waits for a programmable number of cycles, which gives surrounding logic time to bring the system to a stop. After that it flips the reference select and re-enables the phase detector. The downstream clock enables stay low until the lock indication has been high for a programmable run of consecutive cycles.

The analog loop, the detection of a lost clock and the clock multiplexer all sit outside the block and appear here only as pins. The block assumes that all status inputs are already synchronous to `clk`. Every output comes straight from a flop. The sequencer is symmetric: after a failover to the secondary reference, a failure of the secondary starts the same sequence back toward the primary. At power-up the block qualifies lock on the primary reference before it enables any clock output.

Top module: `clk_failover_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ref_sel`=0, `pd_en`=1, `clk_en`=all zeros and `fault`=0.
- R2: When the flag of the active reference (`ref_bad0` if `ref_sel`=0, `ref_bad1` if `ref_sel`=1) is sampled high in the running or relocking phase, `pd_en` and every bit of `clk_en` read 0 after that same edge.
- R3: `ref_sel` toggles on the (`delay_cfg`+1)-th rising edge after the edge that sampled the failure. A value of 0 switches on the next edge, and 31 gives a latency of 32 edges.
- R4: `ref_sel` only changes while `pd_en` is 0, and `pd_en` returns to 1 one edge after `ref_sel` toggles.
- R5: After `pd_en` returns to 1, `clk_en` stays 0 until `lock_in` has been sampled high on `lock_cfg`+1 consecutive edges. `clk_en` goes to all ones after the last of those edges.
- R6: Any sample of `lock_in` at 0 during qualification restarts the consecutive count from zero.
- R7: While both flags are high during the hold, `ref_sel` does not change and `pd_en` and `clk_en` stay 0. `fault` rises and then stays 1 until reset.
- R8: In the running phase, the flag of the inactive reference has no effect on any output.
- R9: After reset the block enables the outputs on the primary reference only after the same lock qualification as in R5, counted from the first edge with `rst` low.
- R10: From the secondary reference, `ref_bad1` starts the same sequence and returns `ref_sel` to 0.
- R11: The internal phase register is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_bad0 | input | 1 | Primary reference reported failed |
| ref_bad1 | input | 1 | Secondary reference reported failed |
| lock_in | input | 1 | Loop lock indication |
| delay_cfg | input | DLY_W (5) | Pre-switch wait, in cycles minus one |
| lock_cfg | input | LOCK_W (4) | Required lock run length minus one |
| pd_en | output | 1 | Phase-detector enable |
| ref_sel | output | 1 | Reference select, 0 = primary, 1 = secondary |
| clk_en | output | N_OUT (2) | Per-output clock enables |
| fault | output | 1 | Sticky flag: both references failed |

## Verification
The assertions check on every cycle the invariants that do not depend on time. The phase register must stay one-hot. No clock enable may be high while the detector is frozen. The select may only move while the detector is frozen. `fault` is sticky. Every enable rise must follow a sampled lock. The wait counter must stay within its setting, and a lock drop must clear the qualifier. The exact latencies across a sweep of delay and lock settings can only be shown by the bench's scenarios, which count edges. The same holds for the restart after a lock glitch, for the double-failure hold, for ignoring the inactive flag, and for the return path to the primary reference.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [4:0] {
    PH_IDLE   = 5'b00001,
    PH_HOLD   = 5'b00010,
    PH_SWITCH = 5'b00100,
    PH_RELOCK = 5'b01000,
    PH_RUN    = 5'b10000
  } sw_phase_e;
endpackage

// File: rtl/clksw_dly_cnt.sv
module clksw_dly_cnt #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;

  // Counts cycles spent in the hold phase; saturates at the limit.
  always_ff @(posedge clk) begin
    if (rst || !run)    cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == limit);

  p_dly_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(limit)) |=> (cnt_q <= limit));
endmodule

// File: rtl/clksw_lock_qual.sv
module clksw_lock_qual #(
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              lock_in,
  input  logic [LOCK_W-1:0] need,
  output logic              stable
);
  localparam logic [LOCK_W-1:0] CNT_MAX = '1;
  logic [LOCK_W-1:0] run_q;

  // Number of earlier consecutive high samples, saturating.
  always_ff @(posedge clk) begin
    if (rst || !enable || !lock_in) run_q <= '0;
    else if (run_q != CNT_MAX)      run_q <= run_q + 1'b1;
  end

  assign stable = lock_in && (run_q >= need);

  p_drop_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && !lock_in) |=> (run_q == '0));
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bad0,
  input  logic bad1,
  input  logic wait_done,
  input  logic lock_ok,
  output logic in_hold,
  output logic qual_en,
  output logic pd_en_o,
  output logic sel_o,
  output logic run_o,
  output logic fault_o
);
  sw_phase_e ph_q, ph_d;
  logic sel_q, pd_q, run_q, fault_q;
  logic act_bad, tgt_bad;

  assign act_bad = sel_q ? bad1 : bad0;
  assign tgt_bad = sel_q ? bad0 : bad1;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (act_bad) ph_d = PH_HOLD; else if (lock_ok) ph_d = PH_RUN;
      PH_RUN:    if (act_bad) ph_d = PH_HOLD;
      PH_HOLD:   if (wait_done && !tgt_bad) ph_d = PH_SWITCH;
      PH_SWITCH: ph_d = PH_RELOCK;
      PH_RELOCK: if (act_bad) ph_d = PH_HOLD; else if (lock_ok) ph_d = PH_RUN;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      sel_q   <= 1'b0;
      pd_q    <= 1'b1;
      run_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      if (ph_q == PH_HOLD && ph_d == PH_SWITCH) sel_q <= ~sel_q;
      pd_q    <= !(ph_d == PH_HOLD || ph_d == PH_SWITCH);
      run_q   <= (ph_d == PH_RUN);
      fault_q <= fault_q | ((ph_q == PH_HOLD) & bad0 & bad1);
    end
  end

  assign in_hold = (ph_q == PH_HOLD);
  assign qual_en = (ph_q == PH_IDLE) || (ph_q == PH_RELOCK);
  assign pd_en_o = pd_q;
  assign sel_o   = sel_q;
  assign run_o   = run_q;
  assign fault_o = fault_q;

  p_phase_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot(ph_q));
  p_gated_when_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_q |-> !run_q);
  p_sel_only_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> !pd_q);
  p_detector_back_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SWITCH) |=> pd_q);
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q);
endmodule

// File: rtl/clk_failover_seq.sv
module clk_failover_seq #(
  parameter int DLY_W  = 5,
  parameter int LOCK_W = 4,
  parameter int N_OUT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_bad0,
  input  logic              ref_bad1,
  input  logic              lock_in,
  input  logic [DLY_W-1:0]  delay_cfg,
  input  logic [LOCK_W-1:0] lock_cfg,
  output logic              pd_en,
  output logic              ref_sel,
  output logic [N_OUT-1:0]  clk_en,
  output logic              fault
);
  logic in_hold, qual_en, wait_done, lock_ok, run_en;

  clksw_dly_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .run(in_hold), .limit(delay_cfg), .done(wait_done)
  );

  clksw_lock_qual #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .enable(qual_en), .lock_in(lock_in),
    .need(lock_cfg), .stable(lock_ok)
  );

  clksw_fsm u_fsm (
    .clk(clk), .rst(rst), .bad0(ref_bad0), .bad1(ref_bad1),
    .wait_done(wait_done), .lock_ok(lock_ok), .in_hold(in_hold),
    .qual_en(qual_en), .pd_en_o(pd_en), .sel_o(ref_sel),
    .run_o(run_en), .fault_o(fault)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_en
    assign clk_en[g] = run_en;
  end

  p_enable_after_lock_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en[0]) |-> $past(lock_in));
endmodule

// File: tb/tb_clk_failover_seq.sv
module tb_clk_failover_seq;
  logic clk = 1'b0;
  logic rst, ref_bad0, ref_bad1, lock_in;
  logic [4:0] delay_cfg;
  logic [3:0] lock_cfg;
  logic pd_en, ref_sel, fault;
  logic [1:0] clk_en;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  clk_failover_seq dut (
    .clk(clk), .rst(rst), .ref_bad0(ref_bad0), .ref_bad1(ref_bad1),
    .lock_in(lock_in), .delay_cfg(delay_cfg), .lock_cfg(lock_cfg),
    .pd_en(pd_en), .ref_sel(ref_sel), .clk_en(clk_en), .fault(fault)
  );

  localparam int NV = 6;
  localparam int DLY_T [NV] = '{0, 31, 5, 1, 17, 2};
  localparam int LCK_T [NV] = '{0, 3, 0, 15, 7, 1};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_bad(input logic s, input logic v);
    if (s) ref_bad1 = v; else ref_bad0 = v;
  endtask

  // Failover from the current reference with lock held high throughout.
  task automatic failover(input int d, input int k);
    logic s;
    int got;
    s = ref_sel;
    set_bad(s, 1'b1);
    step();
    chk("R2 pd_en frozen", pd_en, 0);
    chk("R2 clk_en gated", clk_en, 0);
    got = -1;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (ref_sel != s) begin got = i; break; end
    end
    chk(s ? "R3/R10 select latency back to primary" : "R3 select latency", got, d + 1);
    step();
    chk("R4 pd_en back after select", pd_en, 1);
    got = -1;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (clk_en == 2'b11) begin got = i; break; end
    end
    chk("R5 relock qualification length", got, k + 1);
    set_bad(s, 1'b0);
  endtask

  initial begin
    int got;
    logic s;
    rst = 1'b1; ref_bad0 = 1'b0; ref_bad1 = 1'b0; lock_in = 1'b0;
    delay_cfg = 5'd0; lock_cfg = 4'd2;
    repeat (3) step();
    chk("R1 reset ref_sel", ref_sel, 0);
    chk("R1 reset pd_en", pd_en, 1);
    chk("R1 reset clk_en", clk_en, 0);
    chk("R1 reset fault", fault, 0);

    // R9: startup qualification on the primary reference
    rst = 1'b0; lock_in = 1'b1;
    got = -1;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (clk_en == 2'b11) begin got = i; break; end
    end
    chk("R9 startup qualification", got, 3);
    chk("R9 primary selected", ref_sel, 0);

    // R8: the inactive flag is ignored while running
    ref_bad1 = 1'b1;
    repeat (5) step();
    chk("R8 pd_en unaffected", pd_en, 1);
    chk("R8 clk_en unaffected", clk_en, 3);
    chk("R8 select unaffected", ref_sel, 0);
    ref_bad1 = 1'b0;
    step();

    // Table-driven sweep of delay and lock settings; it alternates direction
    for (int v = 0; v < NV; v++) begin
      delay_cfg = 5'(DLY_T[v]);
      lock_cfg  = 4'(LCK_T[v]);
      failover(DLY_T[v], LCK_T[v]);
      step();
    end

    // R6: a lock glitch restarts the count
    delay_cfg = 5'd0; lock_cfg = 4'd3;
    s = ref_sel;
    lock_in = 1'b0;
    set_bad(s, 1'b1);
    step(); step(); step();
    chk("R6 relock phase entered", pd_en, 1);
    lock_in = 1'b1;
    step(); step();
    lock_in = 1'b0;
    step();
    chk("R6 still gated after drop", clk_en, 0);
    lock_in = 1'b1;
    got = -1;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (clk_en == 2'b11) begin got = i; break; end
    end
    chk("R6 count restarted", got, 4);
    set_bad(s, 1'b0);
    step();

    // R7: both references failed
    delay_cfg = 5'd3;
    s = ref_sel;
    ref_bad0 = 1'b1; ref_bad1 = 1'b1;
    step(); step();
    repeat (6) step();
    chk("R7 select held", ref_sel, s);
    chk("R7 clk_en gated", clk_en, 0);
    chk("R7 pd_en frozen", pd_en, 0);
    chk("R7 fault raised", fault, 1);
    ref_bad0 = 1'b0; ref_bad1 = 1'b0;
    repeat (10) step();
    chk("R7 fault sticky", fault, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R1 fault cleared by reset", fault, 0);
    chk("R1 select back to primary", ref_sel, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule